// File: doc/BRIEF.md
# Three-pass subranging conversion sequencer

This block is the digital controller of a 12-bit subranging converter that resolves four bits per pass from fifteen comparators. An active-low start strobe puts the sampler into hold on its falling edge. The conversion itself begins on the rising edge. The controller then runs three passes. Before each pass it presents a registered segment select so that the comparator reference taps fall inside the segment already chosen. It waits a programmable settle time. It then reduces the 15-bit thermometer word to a nibble by counting its ones.

When the last nibble is in, the 12-bit code is written to an output latch and the busy flag returns high. The sampler is released to track on the following cycle. The comparators and the resistor ladder lie outside the block. The comparator word arrives on `cmp_word`, and its reference segment is set by `pass_idx` and `seg_sel`.

Top module: `subrange_seq`

## Requirements
- R1: After reset, `hold` is 0, `busy` is 1, `data_out` is 0 and `seg_sel` is 0.
- R2: A falling edge of `convst_n` while idle makes `hold` 1 one cycle later. `busy` stays 1 until `convst_n` rises again.
- R3: The first clock edge that sees `convst_n` high after the hold edge drives `busy` to 0 in the next cycle. `busy` then stays 0 for exactly 3*(SETTLE_CYC+1) cycles, which is 9 with the defaults.
- R4: Each pass's nibble equals the number of ones in `cmp_word` on the last settle cycle of that pass. A thermometer word with a bubble (a 0 below a 1) therefore still gives its ones count.
- R5: `pass_idx` is 0, 1 and 2 for the three passes. `seg_sel` is 8 bits wide, and its upper nibble sits in bits 7..4. During pass 0 it is 0. During pass 1 it is {first nibble, 4'h0}. During pass 2 it is {first nibble, second nibble}.
- R6: `data_out` is {pass0 nibble, pass1 nibble, pass2 nibble}, with the pass0 nibble in bits 11..8. It updates in the cycle `busy` returns to 1. It holds its value until the next conversion completes, including while that conversion runs.
- R7: `hold` is still 1 in the first cycle that `busy` is 1 again. It is 0 in the cycle after that.
- R8: Edges on `convst_n` while `busy` is 0 are ignored. The result is unchanged and no second conversion follows: `busy` stays 1 and `hold` stays 0 afterwards.
- R9: With an ideal comparator model, analog level k (in LSBs, 0..4095) converts to code k. This includes the mid-scale pair 2047 -> 12'h7FF and 2048 -> 12'h800.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convst_n | input | 1 | Active-low convert start, synchronous to clk |
| cmp_word | input | 15 | Thermometer outputs of the comparators |
| hold | output | 1 | 1 = sampler in hold, 0 = track |
| busy | output | 1 | 0 while a conversion runs |
| pass_idx | output | 2 | Index of the current pass |
| seg_sel | output | 8 | Registered segment select of the nibbles resolved so far |
| data_out | output | 12 | Latched conversion result |

## Verification
Two functions can land in the same cycle. One is the capture of the final nibble with the release of `busy`. The other is the arrival of a new start edge that must be ignored. The bench provokes this by pulsing `convst_n` low at several points of a running conversion, up to the last sampling cycle. It then judges the outcome at the ports: the result must equal the code of the first sample, and neither `busy` nor `hold` may move again.

A full sweep of all 4096 levels shows that the segment select feeds back correctly. The bench's comparator model derives its taps from `seg_sel`, so a wrong segment produces a wrong code.

// File: rtl/subrange_pkg.sv
package subrange_pkg;
    typedef enum logic [1:0] {
        ST_TRACK   = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CONV    = 2'd2,
        ST_RELEASE = 2'd3
    } seq_st_e;
endpackage

// File: rtl/thermo_count.sv
module thermo_count #(
    parameter int IN_W  = 15,
    parameter int OUT_W = 4
) (
    input  logic [IN_W-1:0]  therm,
    output logic [OUT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < IN_W; i++) begin
            count = count + OUT_W'(therm[i]);
        end
    end
endmodule

// File: rtl/start_edge.sv
module start_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    output logic fall,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= start_n;
    end

    assign fall = prev_q & ~start_n;
    assign rise = ~prev_q & start_n;
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq #(
    parameter int PASS_BITS  = 4,
    parameter int NUM_PASSES = 3,
    parameter int SETTLE_CYC = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                convst_n,
    input  logic [(2**PASS_BITS)-2:0]           cmp_word,
    output logic                                hold,
    output logic                                busy,
    output logic [$clog2(NUM_PASSES)-1:0]       pass_idx,
    output logic [PASS_BITS*(NUM_PASSES-1)-1:0] seg_sel,
    output logic [PASS_BITS*NUM_PASSES-1:0]     data_out
);
    import subrange_pkg::*;

    localparam int CMP_W  = (2**PASS_BITS) - 1;
    localparam int RES_W  = PASS_BITS * NUM_PASSES;
    localparam int PASS_W = $clog2(NUM_PASSES);
    localparam int CNT_W  = $clog2(SETTLE_CYC + 2);
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASSES - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [PASS_W-1:0] pass;
        logic [CNT_W-1:0]  cnt;
        logic [RES_W-1:0]  acc;
        logic [RES_W-1:0]  data;
        logic              busy;
        logic              hold;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic start_fall, start_rise;
    logic [PASS_BITS-1:0] nib;
    logic [RES_W-1:0] placed;
    int unsigned shamt;

    start_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_n (convst_n),
        .fall    (start_fall),
        .rise    (start_rise)
    );

    thermo_count #(.IN_W(CMP_W), .OUT_W(PASS_BITS)) u_count (
        .therm (cmp_word),
        .count (nib)
    );

    always_comb begin
        shamt  = (NUM_PASSES - 1 - int'(cur_q.pass)) * PASS_BITS;
        placed = {{(RES_W-PASS_BITS){1'b0}}, nib} << shamt;
        nxt_d  = cur_q;
        case (cur_q.st)
            ST_TRACK: begin
                nxt_d.hold = 1'b0;
                if (start_fall) begin
                    nxt_d.hold = 1'b1;
                    nxt_d.st   = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (start_rise) begin
                    nxt_d.st   = ST_CONV;
                    nxt_d.busy = 1'b0;
                    nxt_d.pass = '0;
                    nxt_d.cnt  = CNT_W'(SETTLE_CYC);
                    nxt_d.acc  = '0;
                end
            end
            ST_CONV: begin
                if (cur_q.cnt != '0) begin
                    nxt_d.cnt = cur_q.cnt - CNT_W'(1);
                end else begin
                    nxt_d.acc = cur_q.acc | placed;
                    if (cur_q.pass == LAST_PASS) begin
                        nxt_d.busy = 1'b1;
                        nxt_d.data = cur_q.acc | placed;
                        nxt_d.st   = ST_RELEASE;
                    end else begin
                        nxt_d.pass = cur_q.pass + PASS_W'(1);
                        nxt_d.cnt  = CNT_W'(SETTLE_CYC);
                    end
                end
            end
            default: begin
                nxt_d.hold = 1'b0;
                nxt_d.st   = ST_TRACK;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.busy <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign hold     = cur_q.hold;
    assign busy     = cur_q.busy;
    assign pass_idx = cur_q.pass;
    assign seg_sel  = cur_q.acc[RES_W-1:PASS_BITS];
    assign data_out = cur_q.data;
endmodule

module subrange_seq_chk #(
    parameter int PASS_BITS  = 4,
    parameter int NUM_PASSES = 3,
    parameter int SETTLE_CYC = 2
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                hold,
    input logic                                busy,
    input logic [$clog2(NUM_PASSES)-1:0]       pass_idx,
    input logic [PASS_BITS*(NUM_PASSES-1)-1:0] seg_sel,
    input logic [PASS_BITS*NUM_PASSES-1:0]     data_out
);
    localparam int CONV_CYC = NUM_PASSES * (SETTLE_CYC + 1);
    logic [15:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_cnt_q <= '0;
        else if (busy)       low_cnt_q <= '0;
        else if (low_cnt_q != 16'hFFFF) low_cnt_q <= low_cnt_q + 16'd1;
    end

    // R2
    hold_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> busy);

    // R3
    busy_fall_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> hold);

    // R3
    conv_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (low_cnt_q == 16'(CONV_CYC)));

    // R5
    first_pass_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pass_idx == '0) |-> (seg_sel == '0));

    // R6
    result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy) |-> $stable(data_out));

    // R7
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> hold ##1 !hold);
endmodule

bind subrange_seq subrange_seq_chk #(
    .PASS_BITS(PASS_BITS), .NUM_PASSES(NUM_PASSES), .SETTLE_CYC(SETTLE_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .hold(hold), .busy(busy),
    .pass_idx(pass_idx), .seg_sel(seg_sel), .data_out(data_out)
);

// File: tb/subrange_seq_tb_top.sv
`timescale 1ns/1ps
module subrange_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        convst_n = 1'b1;
    logic [14:0] cmp_word;
    logic        hold, busy;
    logic [1:0]  pass_idx;
    logic [7:0]  seg_sel;
    logic [11:0] data_out;

    int ain = 0;
    bit bub_en = 1'b0;
    int n_chk = 0;
    int n_fail = 0;
    int prev_code = 0;

    always #2 clk = ~clk;

    subrange_seq dut_i (
        .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .cmp_word(cmp_word),
        .hold(hold), .busy(busy), .pass_idx(pass_idx), .seg_sel(seg_sel),
        .data_out(data_out)
    );

    // Comparator model: taps placed inside the segment chosen by seg_sel.
    always_comb begin
        int base, step, ones;
        logic [14:0] w;
        case (pass_idx)
            2'd0:    begin base = 0; step = 256; end
            2'd1:    begin base = int'(seg_sel[7:4]) * 256; step = 16; end
            default: begin base = int'(seg_sel[7:4]) * 256 + int'(seg_sel[3:0]) * 16; step = 1; end
        endcase
        ones = 0;
        for (int k = 1; k <= 15; k++) begin
            w[k-1] = (ain >= base + k * step);
            if (w[k-1]) ones++;
        end
        if (bub_en && ones >= 1 && ones <= 14) begin
            w[ones-1] = 1'b0;
            w[ones]   = 1'b1;
        end
        cmp_word = w;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // dpos: low-cycle index at which to pulse convst_n (-1 = none)
    task automatic do_conv(input int code, input bit bub, input int dpos);
        int low;
        int seg1, seg2;
        ain = code; bub_en = bub;
        seg1 = -1; seg2 = -1;
        @(negedge clk) convst_n = 1'b0;
        @(negedge clk);
        chk(hold == 1'b1, "R2 hold after fall", int'(hold), 1);
        chk(busy == 1'b1, "R2 busy before rise", int'(busy), 1);
        convst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R3 busy low after rise", int'(busy), 0);
        chk(data_out == 12'(prev_code), "R6 old result kept", int'(data_out), prev_code);
        low = 1;
        for (int g = 0; g < 100 && busy == 1'b0; g++) begin
            if (pass_idx == 2'd1) seg1 = int'(seg_sel);
            if (pass_idx == 2'd2) seg2 = int'(seg_sel);
            if (dpos >= 0 && low == dpos)     convst_n = 1'b0;
            if (dpos >= 0 && low == dpos + 1) convst_n = 1'b1;
            @(negedge clk);
            if (busy == 1'b0) low++;
        end
        if (dpos >= 0) convst_n = 1'b1;
        chk(low == 9, "R3 conversion length", low, 9);
        chk(data_out == 12'(code), bub ? "R4 bubble code" : "R9 code", int'(data_out), code);
        chk(seg1 == ((code >> 8) << 4), "R5 pass1 segment", seg1, (code >> 8) << 4);
        chk(seg2 == (code >> 4), "R5 pass2 segment", seg2, code >> 4);
        chk(hold == 1'b1, "R7 hold at busy rise", int'(hold), 1);
        @(negedge clk);
        chk(hold == 1'b0, "R7 track after busy", int'(hold), 0);
        prev_code = code;
        if (dpos >= 0) begin
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                chk(busy == 1'b1 && hold == 1'b0, "R8 no extra conversion",
                    int'({busy, hold}), 2);
            end
            chk(data_out == 12'(code), "R8 result unchanged", int'(data_out), code);
        end
    endtask

    initial begin
        #(190000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hold == 1'b0, "R1 reset hold", int'(hold), 0);
        chk(busy == 1'b1, "R1 reset busy", int'(busy), 1);
        chk(data_out == 12'h000, "R1 reset data", int'(data_out), 0);
        chk(seg_sel == 8'h00, "R1 reset seg", int'(seg_sel), 0);

        do_conv(2047, 1'b0, -1);
        chk(data_out == 12'h7FF, "R9 below mid-scale", int'(data_out), 12'h7FF);
        do_conv(2048, 1'b0, -1);
        chk(data_out == 12'h800, "R9 above mid-scale", int'(data_out), 12'h800);

        for (int c = 0; c < 4096; c++) do_conv(c, 1'b0, -1);
        for (int c = 5; c < 4096; c += 37) do_conv(c, 1'b1, -1);
        do_conv(0, 1'b1, -1);
        do_conv(4095, 1'b1, -1);

        do_conv(12'h5A3, 1'b0, 1);
        do_conv(12'hC3E, 1'b0, 4);
        do_conv(12'h19D, 1'b0, 8);
        do_conv(12'hFFF, 1'b0, 7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule